// File: doc/BRIEF.md
# Tagged-Token Matching Adder Node

This block is one operator node of a dynamic dataflow fabric. Two input arcs, a and b, each deliver tagged tokens. A token is 48 bits wide. The upper 16 bits are an instance tag and the lower 32 bits are a data value. The node adds two data values only when their tags agree. A token that finds no partner waits in a small buffer that belongs to its own arc. Several loop iterations can therefore be in flight at the same time and can arrive in any order.

Each input arc uses two handshakes. An upstream operator raises `x_req` and holds `x_tok` steady until the node pulses `x_take`, which means the token has been latched. The node pulses `x_ack` later, only when a token from that arc has been consumed by a firing. `ack_tag` carries the tag of the consumed pair. A firing sends the sum, under the shared tag, out on arc z. `z_stb` stays high until downstream answers with `z_ack`. While a result is pending, `z_busy` is high and the node latches no new input.

The controller has three states:
- `ST_WAIT` waits for a request and checks that the output is free.
- `ST_SEARCH` compares the latched token against the opposite buffer. It then either fires, stores the token, or stalls.
- `ST_HOLD` holds the result until it is acknowledged.

The transitions are:
- WAIT to SEARCH on an eligible request.
- SEARCH to HOLD on a match.
- SEARCH to WAIT after a store or a stall.
- HOLD to WAIT on `z_ack`.

Top module: `tagadd_node`

## Requirements
- R1: A synchronous active-high reset empties both buffers and drives `z_stb`, `z_busy`, `a_take`, `b_take`, `a_ack` and `b_ack` low.
- R2: While `z_busy` is high, no input token is latched, and neither `a_take` nor `b_take` pulses.
- R3: Tokens are partners when bits 47:32 are equal. The result token carries that tag in bits 47:32 and the sum of the two 32-bit data fields, taken modulo 2^32, in bits 31:0.
- R4: A firing raises `z_stb` and pulses `a_ack` and `b_ack` together for one cycle, with `ack_tag` equal to the matched tag. The arriving token also receives a `take` pulse.
- R5: A token with no partner on the opposite buffer is stored and receives a `take` pulse, with no acknowledge and no output.
- R6: The buffered entry consumed by a firing is freed, so it never matches a second time.
- R7: When several buffered entries on one arc share a tag, the lowest-index entry is matched first. Entries are written into the lowest free index, so the earliest stored entry goes first.
- R8: When a token has no partner and its own buffer (4 entries by default) is full, the token is not taken. Its request stays pending until a firing frees a slot.
- R9: `z_stb` and `z_tok` hold steady until `z_ack` is seen. `z_busy` is high exactly while a result is pending.
- R10: When both arcs request in the same cycle, the arcs are served alternately. Tokens with equal tags presented together produce one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Arc a token offered, held until `a_take` |
| a_tok | input | 48 | Arc a token: tag 47:32, data 31:0 |
| a_take | output | 1 | One-cycle pulse: arc a token latched |
| a_ack | output | 1 | One-cycle pulse: an arc a token was consumed |
| b_req | input | 1 | Arc b token offered, held until `b_take` |
| b_tok | input | 48 | Arc b token: tag 47:32, data 31:0 |
| b_take | output | 1 | One-cycle pulse: arc b token latched |
| b_ack | output | 1 | One-cycle pulse: an arc b token was consumed |
| ack_tag | output | 16 | Tag of the pair consumed by the current firing |
| z_stb | output | 1 | Result token valid, held until `z_ack` |
| z_tok | output | 48 | Result token: tag 47:32, sum 31:0 |
| z_ack | input | 1 | Downstream accepts the result |
| z_busy | output | 1 | A result is pending on arc z |

## Verification
The bench builds the node with its default parameters: 16-bit tags, 32-bit data and four buffer slots per arc. With four slots, a fifth unmatched token on one arc reaches the full-buffer stall after a short sequence. That depth also leaves room for two entries with the same tag, which exercises the lowest-index rule. A 32-bit data field lets an all-ones operand show the modulo wrap directly. The bench also withholds `z_ack` for several cycles, which shows the result staying stable and new requests being refused while the output is busy.

// File: rtl/tagadd_pkg.sv
package tagadd_pkg;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_HOLD   = 2'd2
    } node_state_t;

endpackage

// File: rtl/tagadd_lowest.sv
module tagadd_lowest #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scanning from the top down lets the lowest set bit win.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign any = |vec;

endmodule

// File: rtl/tagadd_buf.sv
module tagadd_buf #(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 16,
    parameter int DATA_W = 32,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IW-1:0]     clr_idx,
    input  logic [TAG_W-1:0]  probe_tag,
    output logic              hit,
    output logic [IW-1:0]     hit_idx,
    output logic [DATA_W-1:0] hit_data,
    output logic              full
);

    logic [DEPTH-1:0]  slot_vld;
    logic [TAG_W-1:0]  slot_tag  [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0]  match_vec;
    logic [DEPTH-1:0]  free_vec;
    logic              free_any;
    logic [IW-1:0]     free_idx;

    // Tag comparators, one per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match_vec[g] = slot_vld[g] && (slot_tag[g] == probe_tag);
        assign free_vec[g]  = !slot_vld[g];
    end

    tagadd_lowest #(.N(DEPTH)) u_hit_pick (
        .vec (match_vec),
        .any (hit),
        .idx (hit_idx)
    );

    tagadd_lowest #(.N(DEPTH)) u_free_pick (
        .vec (free_vec),
        .any (free_any),
        .idx (free_idx)
    );

    assign full     = !free_any;
    assign hit_data = slot_data[hit_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld <= '0;
        end else begin
            if (clr_en) begin
                slot_vld[clr_idx] <= 1'b0;
            end
            if (wr_en && free_any) begin
                slot_vld[free_idx]  <= 1'b1;
                slot_tag[free_idx]  <= wr_tag;
                slot_data[free_idx] <= wr_data;
            end
        end
    end

    assert_no_write_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    assert_clear_only_valid_R6: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> slot_vld[clr_idx]);

    assert_cleared_slot_gone_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !wr_en) |=> !slot_vld[$past(clr_idx)]);

endmodule

// File: rtl/tagadd_node.sv
module tagadd_node
    import tagadd_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int TOK_W = TAG_W + DATA_W,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_req,
    input  logic [TOK_W-1:0] a_tok,
    output logic             a_take,
    output logic             a_ack,
    input  logic             b_req,
    input  logic [TOK_W-1:0] b_tok,
    output logic             b_take,
    output logic             b_ack,
    output logic [TAG_W-1:0] ack_tag,
    output logic             z_stb,
    output logic [TOK_W-1:0] z_tok,
    input  logic             z_ack,
    output logic             z_busy
);

    node_state_t       state;
    logic [TAG_W-1:0]  cur_tag;
    logic [DATA_W-1:0] cur_data;
    logic              cur_is_b;
    logic              pref_b;

    logic a_elig, b_elig, pick_a, pick_b, start;
    logic in_search;
    logic a_hit, b_hit, a_full, b_full;
    logic [IW-1:0]     a_hit_idx, b_hit_idx;
    logic [DATA_W-1:0] a_hit_data, b_hit_data;
    logic opp_hit, own_full;
    logic [DATA_W-1:0] opp_data;
    logic [DATA_W-1:0] sum;
    logic a_wr, b_wr, a_clr, b_clr;

    // Request selection, alternating between arcs.
    assign a_elig = a_req && !a_take;
    assign b_elig = b_req && !b_take;
    assign pick_a = a_elig && (!b_elig || !pref_b);
    assign pick_b = b_elig && !pick_a;
    assign start  = (state == ST_WAIT) && !z_busy && (pick_a || pick_b);

    // Search decode.
    assign in_search = (state == ST_SEARCH);
    assign opp_hit   = cur_is_b ? a_hit : b_hit;
    assign opp_data  = cur_is_b ? a_hit_data : b_hit_data;
    assign own_full  = cur_is_b ? b_full : a_full;
    assign sum       = cur_data + opp_data;

    assign a_wr  = in_search && !cur_is_b && !b_hit && !a_full;
    assign b_wr  = in_search &&  cur_is_b && !a_hit && !b_full;
    assign a_clr = in_search &&  cur_is_b &&  a_hit;
    assign b_clr = in_search && !cur_is_b &&  b_hit;

    tagadd_buf #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_buf_a (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (a_wr),
        .wr_tag    (cur_tag),
        .wr_data   (cur_data),
        .clr_en    (a_clr),
        .clr_idx   (a_hit_idx),
        .probe_tag (cur_tag),
        .hit       (a_hit),
        .hit_idx   (a_hit_idx),
        .hit_data  (a_hit_data),
        .full      (a_full)
    );

    tagadd_buf #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_buf_b (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (b_wr),
        .wr_tag    (cur_tag),
        .wr_data   (cur_data),
        .clr_en    (b_clr),
        .clr_idx   (b_hit_idx),
        .probe_tag (cur_tag),
        .hit       (b_hit),
        .hit_idx   (b_hit_idx),
        .hit_data  (b_hit_data),
        .full      (b_full)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT;
        end else begin
            unique case (state)
                ST_WAIT:   if (start) state <= ST_SEARCH;
                ST_SEARCH: state <= opp_hit ? ST_HOLD : ST_WAIT;
                ST_HOLD:   if (z_ack) state <= ST_WAIT;
                default:   state <= ST_WAIT;
            endcase
        end
    end

    // Registered outputs and the latched token.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_take   <= 1'b0;
            b_take   <= 1'b0;
            a_ack    <= 1'b0;
            b_ack    <= 1'b0;
            ack_tag  <= '0;
            z_stb    <= 1'b0;
            z_busy   <= 1'b0;
            z_tok    <= '0;
            cur_tag  <= '0;
            cur_data <= '0;
            cur_is_b <= 1'b0;
            pref_b   <= 1'b0;
        end else begin
            a_take <= 1'b0;
            b_take <= 1'b0;
            a_ack  <= 1'b0;
            b_ack  <= 1'b0;
            unique case (state)
                ST_WAIT: begin
                    if (start) begin
                        cur_is_b <= pick_b;
                        pref_b   <= pick_a;
                        cur_tag  <= pick_b ? b_tok[TOK_W-1:DATA_W] : a_tok[TOK_W-1:DATA_W];
                        cur_data <= pick_b ? b_tok[DATA_W-1:0]     : a_tok[DATA_W-1:0];
                    end
                end
                ST_SEARCH: begin
                    if (opp_hit) begin
                        a_take  <= !cur_is_b;
                        b_take  <= cur_is_b;
                        a_ack   <= 1'b1;
                        b_ack   <= 1'b1;
                        ack_tag <= cur_tag;
                        z_stb   <= 1'b1;
                        z_busy  <= 1'b1;
                        z_tok   <= {cur_tag, sum};
                    end else if (!own_full) begin
                        a_take <= !cur_is_b;
                        b_take <= cur_is_b;
                    end
                end
                ST_HOLD: begin
                    if (z_ack) begin
                        z_stb  <= 1'b0;
                        z_busy <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
        (z_stb && !z_ack) |=> (z_stb && $stable(z_tok)));

    assert_acks_paired_R4: assert property (@(posedge clk) disable iff (rst)
        a_ack |-> (b_ack && z_stb && ack_tag == z_tok[TOK_W-1:DATA_W]));

    assert_one_take_R10: assert property (@(posedge clk) disable iff (rst)
        !(a_take && b_take));

    assert_fire_only_when_free_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(z_stb) |-> !$past(z_busy));

    assert_no_take_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (z_busy && $past(z_busy)) |-> !(a_take || b_take));

endmodule

// File: tb/test_tagadd_node.sv
module test_tagadd_node;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_req = 1'b0, b_req = 1'b0;
    logic [47:0] a_tok = '0, b_tok = '0;
    logic        a_take, a_ack, b_take, b_ack;
    logic [15:0] ack_tag;
    logic        z_stb, z_busy;
    logic [47:0] z_tok;
    logic        z_ack = 1'b0;

    int errors = 0, checks = 0;
    int a_acks = 0, b_acks = 0, results = 0, cycles = 0;
    bit zack_en = 1'b1;
    logic [47:0] exp_q[$];

    always #10 clk = ~clk;

    tagadd_node i_tagadd_node (
        .clk(clk), .rst(rst),
        .a_req(a_req), .a_tok(a_tok), .a_take(a_take), .a_ack(a_ack),
        .b_req(b_req), .b_tok(b_tok), .b_take(b_take), .b_ack(b_ack),
        .ack_tag(ack_tag), .z_stb(z_stb), .z_tok(z_tok),
        .z_ack(z_ack), .z_busy(z_busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input bit sb, input logic [15:0] tg, input logic [31:0] dv,
                        input int limit, output bit ok);
        int n = 0;
        ok = 1'b0;
        if (sb) begin b_tok = {tg, dv}; b_req = 1'b1; end
        else    begin a_tok = {tg, dv}; a_req = 1'b1; end
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (sb ? b_take : a_take) begin ok = 1'b1; break; end
        end
        if (sb) b_req = 1'b0; else a_req = 1'b0;
    endtask

    task automatic put(input bit sb, input logic [15:0] tg, input logic [31:0] dv, input string req);
        bit ok;
        send(sb, tg, dv, 40, ok);
        chk(ok, req, 64'(ok), 64'd1);
    endtask

    // Monitor: scoreboard compare and downstream acknowledge.
    always @(negedge clk) begin
        if (!rst) begin
            if (a_ack) begin
                a_acks++;
                chk(ack_tag == z_tok[47:32], "R4 ack_tag", 64'(ack_tag), 64'(z_tok[47:32]));
            end
            if (b_ack) b_acks++;
        end
        if (z_ack) begin
            z_ack = 1'b0;
        end else if (!rst && z_stb && zack_en) begin
            results++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected result", 64'(z_tok), 64'd0);
            end else begin
                logic [47:0] e;
                e = exp_q.pop_front();
                chk(z_tok == e, "R3 result token", 64'(z_tok), 64'(e));
            end
            z_ack = 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ok14, okx;
        logic [47:0] held;
        settle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!z_stb && !z_busy, "R1 output idle", {62'd0, z_stb, z_busy}, 64'd0);
        chk(!a_take && !b_take && !a_ack && !b_ack, "R1 handshakes low",
            {60'd0, a_take, b_take, a_ack, b_ack}, 64'd0);

        // R5: unmatched token parked, taken, not acknowledged
        put(1'b0, 16'd5, 32'd10, "R5 take on park");
        settle(4);
        chk(a_acks == 0 && results == 0, "R5 no ack no result", 64'(a_acks + results), 64'd0);

        // R3/R4: partner arrives on b
        exp_q.push_back({16'd5, 32'd30});
        put(1'b1, 16'd5, 32'd20, "R4 take on fire");
        settle(5);
        chk(a_acks == 1 && b_acks == 1, "R4 both acks", 64'(a_acks * 16 + b_acks), 64'h11);
        chk(results == 1, "R3 one result", 64'(results), 64'd1);

        // R6: consumed entry freed; a second tag-5 b token must park
        put(1'b1, 16'd5, 32'd7, "R6 park after free");
        settle(4);
        chk(results == 1, "R6 no rematch", 64'(results), 64'd1);
        exp_q.push_back({16'd5, 32'd8});
        put(1'b0, 16'd5, 32'd1, "R6 later partner");
        settle(5);

        // R3: modulo wrap
        exp_q.push_back({16'd3, 32'd1});
        put(1'b0, 16'd3, 32'hFFFF_FFFF, "R3 wrap park");
        put(1'b1, 16'd3, 32'd2, "R3 wrap fire");
        settle(5);

        // R3: mismatched tags do not fire
        put(1'b0, 16'd1, 32'd50, "R3 park tag1");
        put(1'b1, 16'd2, 32'd60, "R3 park tag2");
        settle(4);
        chk(results == 3, "R3 mismatch no fire", 64'(results), 64'd3);
        exp_q.push_back({16'd2, 32'd61});
        put(1'b0, 16'd2, 32'd1, "R3 tag2 match");
        settle(5);
        exp_q.push_back({16'd1, 32'd52});
        put(1'b1, 16'd1, 32'd2, "R3 tag1 match");
        settle(5);

        // R7: duplicate tags, lowest index first
        put(1'b0, 16'd7, 32'd1, "R7 park first");
        put(1'b0, 16'd7, 32'd2, "R7 park second");
        exp_q.push_back({16'd7, 32'd101});
        put(1'b1, 16'd7, 32'd100, "R7 first match");
        settle(5);
        exp_q.push_back({16'd7, 32'd202});
        put(1'b1, 16'd7, 32'd200, "R7 second match");
        settle(5);

        // R8: full buffer stalls an unmatched token
        for (int i = 0; i < 4; i++) put(1'b0, 16'(10 + i), 32'(1 + i), "R8 fill");
        fork
            send(1'b0, 16'd14, 32'd5, 200, ok14);
            begin
                settle(12);
                chk(a_req == 1'b1, "R8 stalled not taken", 64'(a_req), 64'd1);
                exp_q.push_back({16'd10, 32'd101});
                put(1'b1, 16'd10, 32'd100, "R8 free a slot");
            end
        join
        chk(ok14, "R8 taken after free", 64'(ok14), 64'd1);
        for (int i = 1; i < 5; i++) begin
            exp_q.push_back({16'(10 + i), 32'(1 + i)});
            put(1'b1, 16'(10 + i), 32'd0, "R8 drain");
            settle(4);
        end
        settle(4);

        // R10: simultaneous requests
        exp_q.push_back({16'd20, 32'd3});
        fork
            put(1'b0, 16'd20, 32'd1, "R10 a served");
            put(1'b1, 16'd20, 32'd2, "R10 b served");
        join
        settle(5);
        fork
            put(1'b0, 16'd21, 32'd4, "R10 a park");
            put(1'b1, 16'd22, 32'd6, "R10 b park");
        join
        exp_q.push_back({16'd21, 32'd5});
        put(1'b1, 16'd21, 32'd1, "R10 a partner");
        settle(4);
        exp_q.push_back({16'd22, 32'd7});
        put(1'b0, 16'd22, 32'd1, "R10 b partner");
        settle(5);

        // R9/R2: result held while downstream stalls
        zack_en = 1'b0;
        exp_q.push_back({16'd8, 32'd3});
        put(1'b0, 16'd8, 32'd1, "R9 park");
        put(1'b1, 16'd8, 32'd2, "R9 fire");
        settle(2);
        held = z_tok;
        chk(z_stb && z_busy, "R9 strobe held", {62'd0, z_stb, z_busy}, 64'd3);
        send(1'b0, 16'd9, 32'd4, 8, okx);
        chk(!okx, "R2 no take while busy", 64'(okx), 64'd0);
        chk(z_stb && z_tok == held, "R9 token stable", 64'(z_tok), 64'(held));
        zack_en = 1'b1;
        settle(4);
        chk(!z_stb && !z_busy, "R9 released on ack", {62'd0, z_stb, z_busy}, 64'd0);
        put(1'b0, 16'd9, 32'd4, "R2 taken when free");
        exp_q.push_back({16'd9, 32'd4});
        put(1'b1, 16'd9, 32'd0, "R2 partner");
        settle(6);

        chk(exp_q.size() == 0, "R3 all results seen", 64'(exp_q.size()), 64'd0);
        chk(a_acks == b_acks && a_acks == results, "R4 ack count", 64'(a_acks), 64'(results));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule